// File: doc/BRIEF.md
# Coherent Paired-Halfword Parameter Memory

This block is a small parameter store of 16-bit words, shared between a host and an internal timing engine. Two neighbouring words at an even/odd address pair together form a 32-bit value. When the host moves such a value as one long-word access, both halves move as a unit. On a read, both halves are captured in the same clock. On a write, both halves land in the array in the same clock. The engine therefore sees either the whole old pair or the whole new pair, never a mix of the two.

The host can also make plain 16-bit accesses. A long-word access at an odd address loses the pairing guarantee. It is carried out as two separate 16-bit accesses on consecutive clocks, and the host is held off during the second one. The engine reads whole pairs and writes single words. When the host and the engine write the same word in the same clock, the host's write takes effect.

Top module: `param_pair_mem`

## Requirements
- R1: A synchronous active-high reset sets every array word, `h_rdata`, `e_rdata`, `h_rvalid` and `h_busy` to zero.
- R2: A 16-bit host read (`h_long`=0) of word `a` returns `{16'h0, word[a]}` on `h_rdata`, with `h_rvalid` high in the cycle after the request. A 16-bit host write stores `h_wdata[15:0]` into word `a` only.
- R3: A long-word host write to an even address `a` stores `h_wdata[31:16]` into word `a` and `h_wdata[15:0]` into word `a+1` at the same clock edge.
- R4: A long-word host read at an even address `a` returns `{word[a], word[a+1]}`, both sampled at the same clock edge, with `h_rvalid` high one cycle after the request.
- R5: An engine read of pair `p` (`e_rd`) returns `{word[2p], word[2p+1]}` on `e_rdata` one cycle later, both halves sampled at the same edge.
- R6: An engine read that lands in the same cycle as a host commit to the same pair returns the values from before the commit.
- R7: When the host and the engine write the same word in the same cycle, the host data is stored.
- R8: An engine write (`e_wr`) stores `e_wdata` into word `e_waddr` only.
- R9: A long-word host write at an odd address `a` stores `h_wdata[31:16]` into word `a` at the first edge. It stores `h_wdata[15:0]` into word `(a+1) mod 64` at the next edge. `h_busy` is high for exactly that one cycle between the two edges.
- R10: A long-word host read at an odd address `a` samples word `a` into `h_rdata[31:16]` at the first edge and word `(a+1) mod 64` into `h_rdata[15:0]` at the second edge. `h_rvalid` is low after the first edge and high after the second.
- R11: A host read or write presented while `h_busy` is high is ignored: it changes no word and raises no `h_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_addr | input | 6 | Host word address |
| h_wdata | input | 32 | Host write data (upper half goes to the lower address) |
| h_long | input | 1 | 1 = long-word access, 0 = 16-bit access |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_rdata | output | 32 | Host read data |
| h_rvalid | output | 1 | Host read data valid (one-cycle pulse) |
| h_busy | output | 1 | Second phase of an odd long-word access in progress |
| e_pair | input | 5 | Engine pair index for reads |
| e_rd | input | 1 | Engine pair read request |
| e_rdata | output | 32 | Engine pair read data |
| e_waddr | input | 6 | Engine word write address |
| e_wr | input | 1 | Engine word write enable |
| e_wdata | input | 16 | Engine write data |

## Verification
The properties assume the host never raises `h_rd` and `h_wr` in the same cycle. The stimulus picks at most one host operation per cycle, so this always holds. The pair-coherence property also assumes that no engine write hits the pair between the host commit and the engine read it observes, and the property's antecedent requires this. Beyond those two assumptions, random traffic is bunched onto a few low addresses so that host/engine collisions, odd long-word accesses and requests made while busy occur often.

// File: rtl/param_pair_mem.sv
module param_pair_mem #(
  parameter int AW = 6,
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   h_addr,
  input  logic [2*HW-1:0] h_wdata,
  input  logic            h_long,
  input  logic            h_rd,
  input  logic            h_wr,
  output logic [2*HW-1:0] h_rdata,
  output logic            h_rvalid,
  output logic            h_busy,
  input  logic [AW-2:0]   e_pair,
  input  logic            e_rd,
  output logic [2*HW-1:0] e_rdata,
  input  logic [AW-1:0]   e_waddr,
  input  logic            e_wr,
  input  logic [HW-1:0]   e_wdata
);
  localparam int NW = 1 << AW;
  localparam int LW = 2 * HW;

  logic [HW-1:0] mem [NW];
  logic          ph2, ph2_wr;
  logic [AW-1:0] ph2_addr;
  logic [HW-1:0] ph2_data;

  wire            go    = (h_rd | h_wr) & ~ph2;
  wire            mis   = h_long & h_addr[0];
  wire [AW-1:0]   a_odd = {h_addr[AW-1:1], 1'b1};

  assign h_busy = ph2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
      ph2      <= 1'b0;
      ph2_wr   <= 1'b0;
      ph2_addr <= '0;
      ph2_data <= '0;
      h_rdata  <= '0;
      h_rvalid <= 1'b0;
      e_rdata  <= '0;
    end else begin
      h_rvalid <= (go & h_rd & ~mis) | (ph2 & ~ph2_wr);

      if (e_rd) e_rdata <= {mem[{e_pair, 1'b0}], mem[{e_pair, 1'b1}]};

      if (ph2 & ~ph2_wr)
        h_rdata[HW-1:0] <= mem[ph2_addr];
      else if (go & h_rd) begin
        if (mis)          h_rdata[LW-1:HW] <= mem[h_addr];
        else if (h_long)  h_rdata <= {mem[h_addr], mem[a_odd]};
        else              h_rdata <= {{HW{1'b0}}, mem[h_addr]};
      end

      // engine first, host last: host wins on the same word
      if (e_wr) mem[e_waddr] <= e_wdata;
      if (ph2 & ph2_wr)
        mem[ph2_addr] <= ph2_data;
      else if (go & h_wr) begin
        if (h_long & ~h_addr[0]) begin
          mem[h_addr] <= h_wdata[LW-1:HW];
          mem[a_odd]  <= h_wdata[HW-1:0];
        end else begin
          mem[h_addr] <= h_long ? h_wdata[LW-1:HW] : h_wdata[HW-1:0];
        end
      end

      ph2      <= go & mis;
      ph2_wr   <= h_wr;
      ph2_addr <= h_addr + 1'b1;
      ph2_data <= h_wdata[HW-1:0];
    end
  end
endmodule

// File: rtl/param_pair_mem_chk.sv
module param_pair_mem_chk #(
  parameter int AW = 6,
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   h_addr,
  input logic [2*HW-1:0] h_wdata,
  input logic            h_long,
  input logic            h_rd,
  input logic            h_wr,
  input logic [2*HW-1:0] h_rdata,
  input logic            h_rvalid,
  input logic            h_busy,
  input logic [AW-2:0]   e_pair,
  input logic            e_rd,
  input logic [2*HW-1:0] e_rdata,
  input logic [AW-1:0]   e_waddr,
  input logic            e_wr,
  input logic [HW-1:0]   e_wdata
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!h_rvalid && !h_busy && h_rdata == '0 && e_rdata == '0));

  assert_short_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (h_rd && !h_wr && !h_busy && !(h_long && h_addr[0])) |=> h_rvalid);

  assert_engine_sees_whole_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (h_wr && !h_rd && h_long && !h_addr[0] && !h_busy && !e_wr) ##1
    (e_rd && !e_wr && e_pair == $past(h_addr[AW-1:1]))
    |=> e_rdata == $past(h_wdata, 2));

  assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    h_busy |=> !h_busy);

  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(h_busy) |-> $past(h_long && h_addr[0] && (h_rd || h_wr)));

  assert_split_read_timing_R10: assert property (@(posedge clk) disable iff (rst)
    (h_rd && !h_wr && h_long && h_addr[0] && !h_busy) |=> !h_rvalid ##1 h_rvalid);

  assert_busy_blocks_read_R11: assert property (@(posedge clk) disable iff (rst)
    (h_busy && $past(h_wr && !h_rd)) |=> !h_rvalid);
endmodule

bind param_pair_mem param_pair_mem_chk #(.AW(AW), .HW(HW)) u_chk (.*);

// File: tb/sim_param_pair_mem.sv
`timescale 1ns/1ps
module sim_param_pair_mem;
  logic        clk = 1'b0, rst = 1'b1;
  logic [5:0]  h_addr = '0, e_waddr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_long = 0, h_rd = 0, h_wr = 0, e_rd = 0, e_wr = 0;
  logic [4:0]  e_pair = '0;
  logic [15:0] e_wdata = '0;
  logic [31:0] h_rdata, e_rdata;
  logic        h_rvalid, h_busy;

  param_pair_mem u0 (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] m [64];
  bit          mb, mwr;
  logic [5:0]  mpa;
  logic [15:0] mpd, hold_up;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pair_of(input logic [4:0] p);
    return {m[{p, 1'b0}], m[{p, 1'b1}]};
  endfunction

  // drive one cycle, advance reference model, check at next falling edge
  task automatic cyc(input bit hr, hw, hl, input logic [5:0] ha, input logic [31:0] hd,
                     input bit er, input logic [4:0] ep,
                     input bit ew, input logic [5:0] ewa, input logic [15:0] ewd);
    bit go, mis, rv;
    logic [31:0] exp_h, exp_e;
    string htag;
    h_rd = hr; h_wr = hw; h_long = hl; h_addr = ha; h_wdata = hd;
    e_rd = er; e_pair = ep; e_wr = ew; e_waddr = ewa; e_wdata = ewd;
    go = (hr | hw) & !mb;   // R11
    mis = hl & ha[0];
    rv = 0; exp_h = h_rdata; htag = "R2";
    if (mb && !mwr) begin rv = 1; exp_h = {hold_up, m[mpa]}; htag = "R10"; end
    else if (go && hr && !mis) begin
      rv = 1;
      exp_h = hl ? {m[ha], m[{ha[5:1], 1'b1}]} : {16'h0, m[ha]};
      htag = hl ? "R4" : "R2";
    end
    if (go && hr && mis) hold_up = m[ha];
    exp_e = er ? pair_of(ep) : e_rdata;   // R5, R6: pre-commit values
    if (ew) m[ewa] = ewd;                 // R8
    if (mb && mwr) m[mpa] = mpd;          // R9
    else if (go && hw) begin
      if (!hl) m[ha] = hd[15:0];
      else if (!mis) begin m[ha] = hd[31:16]; m[{ha[5:1], 1'b1}] = hd[15:0]; end  // R3
      else m[ha] = hd[31:16];
    end
    mb = go & mis; mwr = hw; mpa = ha + 6'd1; mpd = hd[15:0];
    @(posedge clk);
    @(negedge clk);
    chk(h_busy == mb, "R9 busy", {31'b0, h_busy}, {31'b0, mb});
    chk(h_rvalid == rv, "R10 rvalid", {31'b0, h_rvalid}, {31'b0, rv});
    if (rv) chk(h_rdata == exp_h, htag, h_rdata, exp_h);
    if (er) chk(e_rdata == exp_e, "R5", e_rdata, exp_e);
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, '0, 0, '0, 0, '0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) m[i] = '0;
    mb = 0; mwr = 0; mpa = '0; mpd = '0; hold_up = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    chk(h_rdata == 0 && e_rdata == 0 && !h_rvalid && !h_busy, "R1", h_rdata | e_rdata, 0);
    for (int p = 0; p < 32; p++) cyc(0, 0, 0, '0, '0, 1, p[4:0], 0, '0, '0);
    chk(e_rdata == 0, "R1 array", e_rdata, 0);

    // R3: aligned long write, engine sees whole pair
    cyc(0, 1, 1, 6'd4, 32'h1111_2222, 0, '0, 0, '0, '0);
    cyc(0, 0, 0, '0, '0, 1, 5'd2, 0, '0, '0);
    chk(e_rdata == 32'h1111_2222, "R3", e_rdata, 32'h1111_2222);

    // R6: same-cycle host commit and engine read of the same pair
    cyc(0, 1, 1, 6'd6, 32'hAAAA_BBBB, 0, '0, 0, '0, '0);
    cyc(0, 1, 1, 6'd6, 32'hCCCC_DDDD, 1, 5'd3, 0, '0, '0);
    chk(e_rdata == 32'hAAAA_BBBB, "R6", e_rdata, 32'hAAAA_BBBB);

    // R7: host and engine write the same word
    cyc(0, 1, 0, 6'd9, 32'h0000_A5A5, 0, '0, 1, 6'd9, 16'h5A5A);
    cyc(1, 0, 0, 6'd9, '0, 0, '0, 0, '0, '0);
    chk(h_rdata == 32'h0000_A5A5, "R7", h_rdata, 32'h0000_A5A5);

    // R8: engine write alone
    cyc(0, 0, 0, '0, '0, 0, '0, 1, 6'd12, 16'h1357);
    cyc(1, 0, 0, 6'd12, '0, 0, '0, 0, '0, '0);
    chk(h_rdata == 32'h0000_1357, "R8", h_rdata, 32'h0000_1357);

    // R9 wrap + R11: odd long write at 63, a write during busy is dropped
    cyc(0, 1, 0, 6'd20, 32'h0000_0042, 0, '0, 0, '0, '0);
    cyc(0, 1, 1, 6'd63, 32'h9876_5432, 0, '0, 0, '0, '0);
    chk(h_busy == 1'b1, "R9 busy high", {31'b0, h_busy}, 1);
    cyc(0, 1, 0, 6'd20, 32'h0000_FFFF, 0, '0, 0, '0, '0);
    cyc(1, 0, 0, 6'd20, '0, 0, '0, 0, '0, '0);
    chk(h_rdata == 32'h0000_0042, "R11", h_rdata, 32'h0000_0042);
    cyc(1, 0, 1, 6'd0, '0, 0, '0, 0, '0, '0);
    chk(h_rdata[31:16] == 16'h5432, "R9 wrap", {16'h0, h_rdata[31:16]}, 32'h5432);
    cyc(1, 0, 0, 6'd63, '0, 0, '0, 0, '0, '0);
    chk(h_rdata == 32'h0000_9876, "R9 first half", h_rdata, 32'h0000_9876);

    // R10: odd long read
    cyc(1, 0, 1, 6'd63, '0, 0, '0, 0, '0, '0);
    idle();
    chk(h_rdata == 32'h9876_5432, "R10", h_rdata, 32'h9876_5432);

    // random traffic, biased to few addresses for collisions
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 4;
      bit narrow = ($urandom % 2) == 1;
      logic [5:0] ha = narrow ? 6'($urandom % 8) : 6'($urandom);
      logic [5:0] wa = narrow ? 6'($urandom % 8) : 6'($urandom);
      logic [4:0] ep = narrow ? 5'($urandom % 4) : 5'($urandom);
      cyc(op == 1, op == 2, 1'($urandom), ha, $urandom,
          1'($urandom), ep, ($urandom % 3) == 0, wa, 16'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule